// File: doc/BRIEF.md
# Pipelined Segmented Match-Line CAM

This block is a binary content-addressable memory that holds 144-bit words. Each search compares the key against the stored words in five steps, one step per pipeline stage. The first step covers a short 8-bit head segment. The remaining four steps cover 34-bit body segments, taken from the most significant end towards bit 0. An entry joins a stage's comparison only if it matched in every earlier stage, so the number of comparators that switch drops as a search moves down the pipe.

The pipeline accepts a new key in every cycle. Results leave the pipe in the order the keys entered, five cycles after each key. A write port loads one entry per cycle. Each write carries a flag that marks the entry as usable or unusable.

The block also reports how many entries each stage has enabled. This lets the gating be observed from outside the block.

Top module: `segmatch_cam`

## Requirements
- R1: The key is split into five segments evaluated in this fixed order: stage 0 takes bits [143:136], and stage s (1..4) takes bits [135-34*(s-1) : 102-34*(s-1)].
- R2: A search hits only if all 144 bits equal a usable entry. A single differing bit in any one segment gives a miss.
- R3: A key presented with key_valid high in cycle t produces res_valid in cycle t+5. One search may start every cycle, and results appear in issue order.
- R4: During the cycle in which stage s works on a search, stage_cnt field s (bits [5*s+4:5*s]) equals the number of usable entries that matched every segment before s. Stage 0 counts all usable entries. Every field reads 0 when the stage holds no search.
- R5: When several usable entries match, res_idx gives the lowest index.
- R6: A write in cycle w is seen by searches issued in cycle w+1 or later. Searches issued in cycle w or earlier see the old content in every stage, including stages that run after cycle w.
- R7: An entry written with wr_valid low never produces a hit, whatever data it holds.
- R8: After reset every entry is unusable, res_valid and res_hit are 0, and all stage counts are 0.
- R9: res_hit is high only together with res_valid, and res_idx is 0 whenever res_hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | 4 | Entry number to write |
| wr_data | input | 144 | Word stored in the entry |
| wr_valid | input | 1 | Usable flag stored with the word |
| key_valid | input | 1 | Starts a search this cycle |
| key | input | 144 | Search word |
| res_valid | output | 1 | Result of the search issued five cycles earlier |
| res_hit | output | 1 | At least one usable entry matched all segments |
| res_idx | output | 4 | Lowest matching entry number |
| stage_cnt | output | 25 | Five 5-bit counts of enabled entries, field s for stage s |

## Verification
The assertions assume that reset is held low from time zero for at least one clock edge. They also assume that key_valid and wr_en are driven to known values at every edge after reset. The stimulus drives all inputs at falling edges and keeps them at 0 during reset. The bench only issues searches after the array has been loaded through the write port, except for the write-visibility test, which overlaps writes with searches in flight on purpose. Bursts of back-to-back keys are always followed by five idle cycles, so the stage counts return to zero before the next test.

// File: rtl/segcam_pkg.sv
package segcam_pkg;
    localparam int KEY_W  = 144;
    localparam int NSEG   = 5;
    localparam int HEAD_W = 8;
    localparam int BODY_W = 34;

    // Width of segment s
    function automatic int seg_w(input int s);
        return (s == 0) ? HEAD_W : BODY_W;
    endfunction

    // Lowest key bit of segment s; segment 0 sits at the top of the word
    function automatic int seg_lo(input int s);
        return (s == 0) ? (KEY_W - HEAD_W) : (KEY_W - HEAD_W - BODY_W * s);
    endfunction
endpackage

// File: rtl/segcam_bank.sv
// Storage for one segment column. Writes reach this column DELAY cycles
// late, matching the stage that reads it, so a search never sees a
// write issued after it.
module segcam_bank #(
    parameter int ENTRIES = 16,
    parameter int SEG_W   = 34,
    parameter int DELAY   = 0,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [SEG_W-1:0]                wr_slice,
    output logic [ENTRIES-1:0][SEG_W-1:0]   cells
);
    logic             tap_en;
    logic [IDX_W-1:0] tap_idx;
    logic [SEG_W-1:0] tap_slice;

    generate
        if (DELAY == 0) begin : g_direct
            assign tap_en    = wr_en;
            assign tap_idx   = wr_idx;
            assign tap_slice = wr_slice;
        end else begin : g_delay
            logic [DELAY-1:0]            en_d;
            logic [DELAY-1:0][IDX_W-1:0] idx_d;
            logic [DELAY-1:0][SEG_W-1:0] slc_d;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_d <= '0;
                end else begin
                    en_d[0] <= wr_en;
                    for (int d = 1; d < DELAY; d++) en_d[d] <= en_d[d-1];
                end
                idx_d[0] <= wr_idx;
                slc_d[0] <= wr_slice;
                for (int d = 1; d < DELAY; d++) begin
                    idx_d[d] <= idx_d[d-1];
                    slc_d[d] <= slc_d[d-1];
                end
            end
            assign tap_en    = en_d[DELAY-1];
            assign tap_idx   = idx_d[DELAY-1];
            assign tap_slice = slc_d[DELAY-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (tap_en) begin
            cells[tap_idx] <= tap_slice;
        end
    end
endmodule

// File: rtl/segcam_stage.sv
// One compare stage: only enabled entries are compared; survivors are
// registered as the enable vector of the next stage.
module segcam_stage #(
    parameter int ENTRIES = 16,
    parameter int SEG_W   = 34,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0]             en_vec,
    input  logic [SEG_W-1:0]               key_slice,
    input  logic [ENTRIES-1:0][SEG_W-1:0]  cells,
    output logic [ENTRIES-1:0]             surv_q,
    output logic [CNT_W-1:0]               en_cnt
);
    logic [ENTRIES-1:0] pass;

    always_comb begin
        en_cnt = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            pass[e] = en_vec[e] && (cells[e] == key_slice);
            en_cnt  = en_cnt + CNT_W'(en_vec[e]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) surv_q <= '0;
        else        surv_q <= pass;
    end

    AST_SURVIVOR_WAS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((surv_q & ~$past(en_vec)) == '0)); // R4
endmodule

// File: rtl/segcam_pick.sv
// Lowest-index selection over the final survivor vector.
module segcam_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] surv,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (surv[e]) begin
                found = 1'b1;
                idx   = IDX_W'(e);
            end
        end
    end
endmodule

// File: rtl/segmatch_cam.sv
module segmatch_cam
    import segcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [KEY_W-1:0]       wr_data,
    input  logic                   wr_valid,
    input  logic                   key_valid,
    input  logic [KEY_W-1:0]       key,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [IDX_W-1:0]       res_idx,
    output logic [NSEG*CNT_W-1:0]  stage_cnt
);
    // Usable flags: read by stage 0 only, so written without delay
    logic [ENTRIES-1:0] ent_vld;
    always_ff @(posedge clk) begin
        if (!rst_n)     ent_vld <= '0;
        else if (wr_en) ent_vld[wr_idx] <= wr_valid;
    end

    // Key and valid pipelines
    logic [NSEG-1:0][KEY_W-1:0] key_pipe;
    logic [NSEG-1:0]            vld_pipe;
    assign key_pipe[0] = key;

    always_ff @(posedge clk) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[NSEG-2:0], key_valid};
    end

    always_ff @(posedge clk) begin
        for (int s = 1; s < NSEG; s++) key_pipe[s] <= key_pipe[s-1];
    end

    logic [NSEG-1:0][ENTRIES-1:0] surv;
    logic [NSEG-1:0][CNT_W-1:0]   cnt;

    generate
        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            localparam int LO = seg_lo(s);
            localparam int W  = seg_w(s);
            logic [ENTRIES-1:0][W-1:0] cells;
            logic [ENTRIES-1:0]        en_vec;

            segcam_bank #(.ENTRIES(ENTRIES), .SEG_W(W), .DELAY(s)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .wr_idx   (wr_idx),
                .wr_slice (wr_data[LO +: W]),
                .cells    (cells)
            );

            if (s == 0) begin : g_first
                assign en_vec = ent_vld & {ENTRIES{key_valid}};
            end else begin : g_next
                assign en_vec = surv[s-1];
            end

            segcam_stage #(.ENTRIES(ENTRIES), .SEG_W(W)) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .en_vec    (en_vec),
                .key_slice (key_pipe[s][LO +: W]),
                .cells     (cells),
                .surv_q    (surv[s]),
                .en_cnt    (cnt[s])
            );

            assign stage_cnt[s*CNT_W +: CNT_W] = cnt[s];

            if (s > 0) begin : g_chk
                AST_ENABLES_NEVER_GROW: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> (cnt[s] <= $past(cnt[s-1]))); // R4
            end
        end
    endgenerate

    logic             found;
    logic [IDX_W-1:0] pick_idx;

    segcam_pick #(.ENTRIES(ENTRIES)) u_pick (
        .surv  (surv[NSEG-1]),
        .found (found),
        .idx   (pick_idx)
    );

    assign res_valid = vld_pipe[NSEG-1];
    assign res_hit   = res_valid & found;
    assign res_idx   = res_hit ? pick_idx : '0;

    // Cycles since reset, saturating, to guard the latency window
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
    end

    AST_FIVE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd5) |-> (res_valid == $past(key_valid, 5))); // R3
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid); // R9
    AST_IDX_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_idx == '0)); // R9
    AST_PICK_IS_SURVIVOR: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> surv[NSEG-1][res_idx]); // R5
endmodule

// File: tb/sim_segmatch_cam.sv
module sim_segmatch_cam;
    localparam int CLK_NS = 10;
    localparam int NROW   = 13;

    // Row: [15:12] entry, [11:9] flipped segment (7 = none), [8] hit, [7:4] idx
    localparam logic [15:0] VEC [NROW] = '{
        {4'd0,  3'd7, 1'b1, 4'd0,  4'd0},
        {4'd3,  3'd7, 1'b1, 4'd3,  4'd0},
        {4'd7,  3'd7, 1'b1, 4'd7,  4'd0},
        {4'd11, 3'd7, 1'b1, 4'd11, 4'd0},
        {4'd5,  3'd7, 1'b1, 4'd5,  4'd0},
        {4'd14, 3'd7, 1'b0, 4'd0,  4'd0},
        {4'd15, 3'd7, 1'b0, 4'd0,  4'd0},
        {4'd2,  3'd0, 1'b0, 4'd0,  4'd0},
        {4'd2,  3'd1, 1'b0, 4'd0,  4'd0},
        {4'd6,  3'd2, 1'b0, 4'd0,  4'd0},
        {4'd9,  3'd3, 1'b0, 4'd0,  4'd0},
        {4'd10, 3'd4, 1'b0, 4'd0,  4'd0},
        {4'd12, 3'd7, 1'b0, 4'd0,  4'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, wr_valid = 1'b0, key_valid = 1'b0;
    logic [3:0]   wr_idx = '0;
    logic [143:0] wr_data = '0, key = '0;
    logic         res_valid, res_hit;
    logic [3:0]   res_idx;
    logic [24:0]  stage_cnt;

    int total = 0, bad = 0;
    bit wd_fired = 0;

    logic [143:0] sh_data [16];
    bit           sh_vld  [16];

    always #(CLK_NS/2) clk = ~clk;

    segmatch_cam u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_valid(wr_valid), .key_valid(key_valid),
        .key(key), .res_valid(res_valid), .res_hit(res_hit),
        .res_idx(res_idx), .stage_cnt(stage_cnt)
    );

    function automatic logic [143:0] mk(input int i);
        logic [3:0] v = 4'(i);
        return {8'hA0 + {6'd0, v[3:2]}, {30'h1234567, v}, {30'h2345678, v},
                {30'h3456789, v}, {30'h0ABCDEF, v}};
    endfunction

    function automatic int lo_bit(input int s);
        return (s == 0) ? 136 : 136 - 34 * s;
    endfunction

    function automatic int wid(input int s);
        return (s == 0) ? 8 : 34;
    endfunction

    function automatic logic [143:0] row_key(input int r);
        logic [143:0] k = mk(int'(VEC[r][15:12]));
        int f = int'(VEC[r][11:9]);
        if (f != 7) k[lo_bit(f)] = ~k[lo_bit(f)];
        return k;
    endfunction

    // Usable entries that agree with k on every segment below s
    function automatic int exp_cnt(input logic [143:0] k, input int s);
        int n = 0;
        for (int e = 0; e < 16; e++) begin
            bit ok = sh_vld[e];
            for (int t = 0; t < s; t++)
                if (((sh_data[e] ^ k) >> lo_bit(t)) & ((144'd1 << wid(t)) - 144'd1)) ok = 0;
            if (ok) n++;
        end
        return n;
    endfunction

    function automatic int cnt_of(input int s);
        return int'(stage_cnt[s*5 +: 5]);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [143:0] d, input bit v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d; wr_valid = v;
        sh_data[idx] = d; sh_vld[idx] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_all;
        for (int e = 0; e < 16; e++) begin sh_data[e] = '0; sh_vld[e] = 0; end
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(res_valid == 0, "R8 res_valid", res_valid, 0);
        chk(res_hit == 0, "R8 res_hit", res_hit, 0);
        chk(stage_cnt == 0, "R8 stage_cnt", stage_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        key_valid = 1'b1; key = mk(0);
        #1 chk(cnt_of(0) == 0, "R8 no usable entries", cnt_of(0), 0);
        @(negedge clk); key_valid = 1'b0;
        idle(6);
        chk(res_hit == 0, "R8 empty array", res_hit, 0);

        // Preload
        for (int e = 0; e < 12; e++) wr(e, mk(e), 1'b1);
        wr(12, mk(5), 1'b1);
        wr(14, mk(14), 1'b0);   // R7: stored but unusable

        // Back-to-back table walk: R1 R2 R3 R4 R5 R7 R9
        for (int k = 0; k < NROW + 5; k++) begin
            @(negedge clk);
            if (k >= 5) begin
                int r = k - 5;
                chk(res_valid == 1, "R3 result in order", res_valid, 1);
                chk(res_hit == VEC[r][8], "R2 hit", res_hit, VEC[r][8]);
                chk(res_idx == VEC[r][7:4], "R5 idx", res_idx, VEC[r][7:4]);
            end
            for (int s = 1; s < 5; s++) begin
                int e = ((k - s) >= 0 && (k - s) < NROW) ? exp_cnt(row_key(k - s), s) : 0;
                chk(cnt_of(s) == e, "R4 stage count", cnt_of(s), e);
            end
            if (k < NROW) begin key_valid = 1'b1; key = row_key(k); end
            else key_valid = 1'b0;
        end
        @(negedge clk);
        chk(res_valid == 0, "R9 idle after burst", res_valid, 0);
        chk(res_idx == 0, "R9 idx zero", res_idx, 0);

        // R4: stage 0 enables all usable entries (13), none without a key
        key_valid = 1'b1; key = mk(1);
        #1 chk(cnt_of(0) == 13, "R4 stage0 count", cnt_of(0), 13);
        @(negedge clk);
        key_valid = 1'b0;
        #1 chk(cnt_of(0) == 0, "R4 stage0 idle", cnt_of(0), 0);
        chk(cnt_of(1) == 4, "R1 head group size", cnt_of(1), 4);
        idle(6);

        // R6: write overlapping searches in flight
        key_valid = 1'b1; key = mk(0);              // cycle w-1
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = mk(13); wr_valid = 1'b1;
        key = mk(13);                               // cycle w
        @(negedge clk);
        wr_en = 1'b0; key = mk(13);                 // cycle w+1
        @(negedge clk);
        key_valid = 1'b0;
        idle(2);
        chk(res_hit == 1 && res_idx == 0, "R6 old content before write", {res_hit, res_idx}, {1'b1, 4'd0});
        @(negedge clk);
        chk(res_hit == 0, "R6 same-cycle search misses", res_hit, 0);
        @(negedge clk);
        chk(res_hit == 1 && res_idx == 0, "R6 later search sees write", {res_hit, res_idx}, {1'b1, 4'd0});
        idle(3);
    endtask

    initial begin
        fork
            run_all();
            begin #(CLK_NS * 20000); wd_fired = 1; end
        join_any
        disable fork;
        if (wd_fired) begin total++; bad++; $display("FAIL watchdog expired"); end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule